// File: doc/BRIEF.md
# Dual-Latch Parallel Output Port

This block is the write side of an eight-channel output controller. A host drives an 8-bit data bus together with three active-low pins: chip select, write strobe and output disable. The block produces one enable bit per output channel. In bus mode a write captures the data into an input latch. The outputs change only when chip select is released, which copies the input latch into an output buffer. In direct mode, which is selected by holding chip select and write low together for long enough, the data pins drive the channel enables straight through.

Chip select, write and disable pass through two-flop synchronisers into the system clock domain, and a state machine acts on the synchronised levels. The disable pin is handled in three ways. It gates the outputs off combinationally. It clears every latch and the state register asynchronously. Its synchronised copy holds the machine in its off state until the release has settled.

The machine has five states. ST_OFF waits out a disable. ST_IDLE means chip select is high. ST_SELECT means chip select is low and write is high. ST_WRITE means both strobes are low while the low-time counter runs. ST_DIRECT is the pass-through mode. The transitions are:
- ST_OFF goes to ST_IDLE once synchronised disable is high.
- ST_IDLE goes to ST_SELECT on chip select low, or to ST_WRITE when both strobes are low.
- ST_SELECT goes to ST_WRITE on write low, or back to ST_IDLE on chip select high.
- ST_WRITE goes to ST_SELECT on write high, to ST_IDLE on chip select high, or to ST_DIRECT when the counter reaches its limit.
- ST_DIRECT goes to ST_SELECT on write high, or to ST_IDLE on chip select high.
- Every state goes to ST_OFF on disable.

Top module: `par_out_port`

## Requirements
- R1: While reset is asserted, and after reset with both strobes high, every bit of chan_en is 0.
- R2: While both synchronised strobes are low in bus mode, the input latch follows data_pin and chan_en keeps its previous value.
- R3: Once write has been high for three clocks, further changes on data_pin do not reach the input latch.
- R4: A rising edge of chip select copies the input latch into the output buffer. chan_en shows the new value after the third rising clock edge that follows the pin change, and not before.
- R5: A chip-select cycle without any write pulse commits the unchanged input latch, so chan_en does not change.
- R6: Direct mode begins when both synchronised strobes have been low for DIRECT_CYCLES+1 consecutive clocks. From then on chan_en equals data_pin combinationally.
- R7: A write phase whose synchronised low time is DIRECT_CYCLES clocks or fewer stays in bus mode, and chan_en does not follow data_pin during it.
- R8: While dis_n_pin is low, chan_en is 0 at once and strobe activity has no effect.
- R9: After dis_n_pin returns high, chan_en stays 0 until a new write. A chip-select cycle without a write then commits 0, because both latches were cleared.
- R10: Bit n of data_pin controls only chan_en bit n.
- R11: When direct mode is left by raising write, chan_en keeps the data_pin value that was present at the release, including after the later chip-select rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_pin | input | 1 | Active-low chip select, asynchronous |
| wr_n_pin | input | 1 | Active-low write strobe, asynchronous |
| dis_n_pin | input | 1 | Active-low output disable, asynchronous |
| data_pin | input | WIDTH | Data bus; bit n belongs to channel n |
| chan_en | output | WIDTH | Channel enables; 1 turns a channel on |

## Verification
A strobe change made between clock edges reaches the state machine on the second rising edge after it. A commit therefore shows on chan_en just after the third edge, and the bench checks the old value after two edges and the new value after three. Disable and direct-mode data act on chan_en without a clock, so those checks sample one time unit after the pin change. Data hold is checked by corrupting data_pin three clocks after write rises, and the direct-mode threshold is checked by holding the strobes low for exactly DIRECT_CYCLES clocks in one case and for DIRECT_CYCLES+5 in another.

// File: rtl/par_out_pkg.sv
package par_out_pkg;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_IDLE   = 3'd1,
        ST_SELECT = 3'd2,
        ST_WRITE  = 3'd3,
        ST_DIRECT = 3'd4
    } port_state_t;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic sync
);
    logic [STAGES-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '1;
        else        stg <= {stg[STAGES-2:0], pin};
    end

    assign sync = stg[STAGES-1];

endmodule

// File: rtl/strobe_fsm.sv
module strobe_fsm
    import par_out_pkg::*;
#(
    parameter int DIRECT_CYCLES = 8
) (
    input  logic clk,
    input  logic clr_n,
    input  logic cs_s,
    input  logic wr_s,
    input  logic dis_s,
    output logic cap_en,
    output logic commit,
    output logic direct_on
);
    localparam int CNT_W = (DIRECT_CYCLES > 2) ? $clog2(DIRECT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIRECT_CYCLES - 1);

    port_state_t state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic cs_d;
    logic both_low;

    assign both_low = !cs_s && !wr_s;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            cnt  <= '0;
            cs_d <= 1'b1;
        end else begin
            cs_d <= cs_s;
            if (state == ST_WRITE && both_low) cnt <= cnt + 1'b1;
            else                               cnt <= '0;
        end
    end

    always_comb begin
        state_nx = state;
        if (!dis_s) begin
            state_nx = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:    state_nx = ST_IDLE;
                ST_IDLE: begin
                    if (!cs_s && !wr_s)     state_nx = ST_WRITE;
                    else if (!cs_s)         state_nx = ST_SELECT;
                end
                ST_SELECT: begin
                    if (cs_s)               state_nx = ST_IDLE;
                    else if (!wr_s)         state_nx = ST_WRITE;
                end
                ST_WRITE: begin
                    if (cs_s)               state_nx = ST_IDLE;
                    else if (wr_s)          state_nx = ST_SELECT;
                    else if (cnt == CNT_LAST) state_nx = ST_DIRECT;
                end
                ST_DIRECT: begin
                    if (cs_s)               state_nx = ST_IDLE;
                    else if (wr_s)          state_nx = ST_SELECT;
                end
                default:                    state_nx = ST_OFF;
            endcase
        end
    end

    always_comb begin
        cap_en    = both_low && dis_s && (state != ST_OFF);
        commit    = cs_s && !cs_d && (state != ST_OFF);
        direct_on = (state == ST_DIRECT);
    end

    AST_DIRECT_NEEDS_STROBES: assert property (@(posedge clk) disable iff (!clr_n)
        (state == ST_DIRECT) |-> $past(!cs_s && !wr_s)); // R6

    AST_DIRECT_AFTER_COUNT: assert property (@(posedge clk) disable iff (!clr_n)
        $rose(direct_on) |-> ($past(cnt) == CNT_LAST)); // R7

endmodule

// File: rtl/latch_pair.sv
module latch_pair #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             cap_en,
    input  logic             commit,
    input  logic             direct_on,
    input  logic [WIDTH-1:0] data_in,
    output logic [WIDTH-1:0] buf_q
);
    logic [WIDTH-1:0] in_q;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)      in_q <= '0;
        else if (cap_en) in_q <= data_in;
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)         buf_q <= '0;
        else if (direct_on) buf_q <= data_in;
        else if (commit)    buf_q <= in_q;
    end

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!clr_n)
        !cap_en |=> $stable(in_q)); // R3

    AST_BUF_HOLDS: assert property (@(posedge clk) disable iff (!clr_n)
        (!commit && !direct_on) |=> $stable(buf_q)); // R2

    AST_COMMIT_COPIES: assert property (@(posedge clk) disable iff (!clr_n)
        (commit && !direct_on) |=> (buf_q == $past(in_q))); // R4

endmodule

// File: rtl/par_out_port.sv
module par_out_port #(
    parameter int WIDTH         = 8,
    parameter int SYNC_STAGES   = 2,
    parameter int DIRECT_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n_pin,
    input  logic             wr_n_pin,
    input  logic             dis_n_pin,
    input  logic [WIDTH-1:0] data_pin,
    output logic [WIDTH-1:0] chan_en
);
    localparam int NPINS = 3;

    logic [NPINS-1:0] raw_pins;
    logic [NPINS-1:0] sync_pins;
    logic             clr_n;
    logic             cap_en, commit, direct_on;
    logic [WIDTH-1:0] buf_q;

    assign raw_pins = {dis_n_pin, wr_n_pin, cs_n_pin};
    assign clr_n    = rst_n & dis_n_pin;

    for (genvar g = 0; g < NPINS; g++) begin : g_sync
        pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (raw_pins[g]),
            .sync  (sync_pins[g])
        );
    end

    strobe_fsm #(.DIRECT_CYCLES(DIRECT_CYCLES)) u_fsm (
        .clk       (clk),
        .clr_n     (clr_n),
        .cs_s      (sync_pins[0]),
        .wr_s      (sync_pins[1]),
        .dis_s     (sync_pins[2]),
        .cap_en    (cap_en),
        .commit    (commit),
        .direct_on (direct_on)
    );

    latch_pair #(.WIDTH(WIDTH)) u_latch (
        .clk       (clk),
        .clr_n     (clr_n),
        .cap_en    (cap_en),
        .commit    (commit),
        .direct_on (direct_on),
        .data_in   (data_pin),
        .buf_q     (buf_q)
    );

    always_comb begin
        if (!dis_n_pin)     chan_en = '0;
        else if (direct_on) chan_en = data_pin;
        else                chan_en = buf_q;
    end

    AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !dis_n_pin |-> (chan_en == '0)); // R8

    AST_RELEASE_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dis_n_pin) |-> (chan_en == '0)); // R9

endmodule

// File: tb/par_out_port_test.sv
module par_out_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int DC = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1;
    logic         wr_n = 1'b1;
    logic         dis_n = 1'b1;
    logic [W-1:0] data = '0;
    logic [W-1:0] chan_en;
    logic [W-1:0] model = '0;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    par_out_port #(.WIDTH(W), .SYNC_STAGES(2), .DIRECT_CYCLES(DC)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_pin  (cs_n),
        .wr_n_pin  (wr_n),
        .dis_n_pin (dis_n),
        .data_pin  (data),
        .chan_en   (chan_en)
    );

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: chan_en=%02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // bus write: outputs switch on the third edge after chip select rises
    task automatic bus_write(logic [W-1:0] v, int wcyc, bit junk);
        cs_n = 1'b0;
        tick(2);
        wr_n = 1'b0;
        data = v;
        tick(wcyc);
        #1 check("R2 R7 no change during write", chan_en, model);
        wr_n = 1'b1;
        tick(3);
        if (junk) data = ~v;
        tick(1);
        cs_n = 1'b1;
        tick(2);
        #1 check("R4 not before third edge", chan_en, model);
        tick(1);
        #1 check(junk ? "R3 late data ignored" : "R4 commit", chan_en, v);
        model = v;
    endtask

    task automatic disable_pulse();
        dis_n = 1'b0;
        #1 check("R8 off at once", chan_en, '0);
        tick(3);
        dis_n = 1'b1;
        tick(4);
        #1 check("R9 stays off after release", chan_en, '0);
        model = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL R4 watchdog: run not finished, expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        data = 8'hA5;
        tick(3);
        #1 check("R1 in reset", chan_en, '0);
        rst_n = 1'b1;
        tick(4);
        #1 check("R1 after reset", chan_en, '0);

        // walking ones
        for (int n = 0; n < W; n++) begin
            bus_write(W'(1) << n, 3, 1'b0);
            check("R10 single channel", chan_en, W'(1) << n);
        end

        // cycle without a write pulse
        bus_write(8'h3C, 4, 1'b0);
        cs_n = 1'b0;
        data = 8'hFF;
        tick(4);
        cs_n = 1'b1;
        tick(4);
        #1 check("R5 no-write cycle", chan_en, 8'h3C);

        // longest low time that must stay in bus mode
        bus_write(8'h96, DC, 1'b1);

        // direct mode
        cs_n = 1'b0; wr_n = 1'b0; data = 8'h5A;
        tick(DC + 5);
        #1 check("R6 direct follows", chan_en, 8'h5A);
        data = 8'hC3;
        #1 check("R6 direct combinational", chan_en, 8'hC3);
        tick(1);
        wr_n = 1'b1;
        tick(4);
        #1 check("R11 hold after exit", chan_en, 8'hC3);
        data = 8'h11;
        tick(4);
        #1 check("R3 ignored after exit", chan_en, 8'hC3);
        cs_n = 1'b1;
        tick(4);
        #1 check("R11 after cs rise", chan_en, 8'hC3);
        model = 8'hC3;

        // disable during direct mode, strobes raised before release
        cs_n = 1'b0; wr_n = 1'b0; data = 8'h7E;
        tick(DC + 5);
        #1 check("R6 direct again", chan_en, 8'h7E);
        dis_n = 1'b0;
        #1 check("R8 off in direct", chan_en, '0);
        tick(2);
        cs_n = 1'b1; wr_n = 1'b1;
        tick(2);
        cs_n = 1'b0; wr_n = 1'b0; tick(3); wr_n = 1'b1; tick(3); cs_n = 1'b1;
        tick(4);
        #1 check("R8 strobes ignored while disabled", chan_en, '0);
        dis_n = 1'b1;
        tick(4);
        #1 check("R9 off after release", chan_en, '0);
        cs_n = 1'b0;
        tick(4);
        cs_n = 1'b1;
        tick(4);
        #1 check("R9 latch cleared", chan_en, '0);
        model = '0;
        bus_write(8'hE7, 3, 1'b0);

        // random writes with occasional disable
        for (int i = 0; i < 30; i++) begin
            logic [W-1:0] v;
            int wc;
            bit jk;
            v  = W'($urandom);
            wc = 2 + int'($urandom % (DC - 1));
            jk = 1'($urandom % 2);
            bus_write(v, wc, jk);
            if (i % 7 == 6) disable_pulse();
        end

        finish_run();
    end
endmodule